// File: doc/BRIEF.md
# GPIO Output Arbiter for Multiple Pin Engines

This block sits between a group of small pin-driving engines and a shared GPIO bank. Each engine owns four pin windows: a wide data window, a narrow set window, a side window and a sampling window. Each window is given by a base pin and a pin count, and it wraps past the top pin back to pin 0. In any clock an engine may post one main write, one side write, both, or neither. The main write goes through the data window or through the set window. Each write lands either on pin levels or on pin output enables.

All writes are resolved pin by pin, and levels and enables are resolved separately. The result is held in registers that drive the pins. A pin that nobody writes keeps its value. The block also hands each engine a view of the GPIO inputs, rotated so that its sampling window starts at bit 0.

Top module: `gpio_out_arbiter`

## Requirements
- R1: While rst_ni is low, every level output is 0 and every enable output is 0, so all pins are inputs.
- R2: A main write with main_src_i=0 uses the data window. Data bit i drives pin (out_base + i) mod 32 for i < out_cnt, where the count runs from 0 to 32. Data bits at or above the count are ignored.
- R3: A main write with main_src_i=1 uses the set window. Only data bits [4:0] are used, and the effective count is min(set_cnt, 5).
- R4: A side write (side_vld_i) uses the side window with the 5-bit side_data_i. The effective count is min(side_cnt, 5), and the window wraps the same way.
- R5: A target flag of 0 writes pin levels (gpio_o) and leaves enables unchanged. A target flag of 1 writes output enables (gpio_oe_o, 1 = drive) and leaves levels unchanged.
- R6: When several engines write the same pin level or the same pin enable in one cycle, the highest-numbered engine wins.
- R7: When an engine's main write and side write hit the same pin level or the same pin enable, the side write wins.
- R8: A pin level or enable that receives no write in a cycle keeps its previous value.
- R9: gpio_o and gpio_oe_o are registered. A write becomes visible after the next rising clock edge, and not before it.
- R10: in_data_o[e] bit i equals gpio_i[(in_base + i) mod 32] for i < in_cnt, and 0 for higher bits. This path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_base_i | input | 8x5 | Data window base pin, per engine |
| out_cnt_i | input | 8x6 | Data window pin count (0..32), per engine |
| set_base_i | input | 8x5 | Set window base pin, per engine |
| set_cnt_i | input | 8x3 | Set window pin count (capped at 5), per engine |
| side_base_i | input | 8x5 | Side window base pin, per engine |
| side_cnt_i | input | 8x3 | Side window pin count (capped at 5), per engine |
| in_base_i | input | 8x5 | Sampling window base pin, per engine |
| in_cnt_i | input | 8x6 | Sampling window pin count (0..32), per engine |
| main_vld_i | input | 8 | Main write present, per engine |
| main_src_i | input | 8 | Main write window: 0 = data window, 1 = set window |
| main_tgt_i | input | 8 | Main write target: 0 = level, 1 = enable |
| main_data_i | input | 8x32 | Main write data, per engine |
| side_vld_i | input | 8 | Side write present, per engine |
| side_tgt_i | input | 8 | Side write target: 0 = level, 1 = enable |
| side_data_i | input | 8x5 | Side write data, per engine |
| gpio_i | input | 32 | Pin input levels |
| gpio_o | output | 32 | Registered pin levels |
| gpio_oe_o | output | 32 | Registered pin output enables |
| in_data_o | output | 8x32 | Rotated, masked input view, per engine |

## Verification
Pin levels and enables are due one rising edge after their writes are presented. The bench drives each write on a falling edge. It reads gpio_o and gpio_oe_o once just before the following rising edge, where they must still hold the old state (R9). It reads them again 1 ns after that edge, where they must match the reference model. The sampling view has no delay, so it is compared 1 ns after the inputs change, within the same half cycle.

// File: rtl/gpio_arb_pkg.sv
package gpio_arb_pkg;
  typedef enum logic {TGT_LEVEL = 1'b0, TGT_DIR = 1'b1} gpio_tgt_e;
  typedef enum logic {SRC_OUT = 1'b0, SRC_SET = 1'b1} main_src_e;
endpackage

// File: rtl/gpio_win_map.sv
module gpio_win_map #(
  parameter int NP = 32,
  parameter int DW = 32,
  parameter int PW = 5,
  parameter int CW = 6
) (
  input  logic [PW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] data_i,
  output logic [NP-1:0] mask_o,
  output logic [NP-1:0] val_o
);
  logic [NP-1:0]   win_mask;
  logic [NP-1:0]   raw;
  logic [2*NP-1:0] dbl_m, dbl_v;

  always_comb begin
    win_mask = '0;
    raw      = '0;
    for (int i = 0; i < NP; i++) begin
      if (i < DW && i < int'(cnt_i)) win_mask[i] = 1'b1;
      if (i < DW) raw[i] = data_i[i];
    end
    dbl_m  = {win_mask, win_mask} << base_i;
    dbl_v  = {raw & win_mask, raw & win_mask} << base_i;
    mask_o = dbl_m[2*NP-1:NP];
    val_o  = dbl_v[2*NP-1:NP];
  end
endmodule

// File: rtl/gpio_in_gather.sv
module gpio_in_gather #(
  parameter int NP = 32,
  parameter int PW = 5,
  parameter int CW = 6
) (
  input  logic [NP-1:0] gpio_i,
  input  logic [PW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  output logic [NP-1:0] data_o
);
  logic [2*NP-1:0] dbl;

  always_comb begin
    dbl = {gpio_i, gpio_i} >> base_i;
    for (int i = 0; i < NP; i++)
      data_o[i] = (i < int'(cnt_i)) ? dbl[i] : 1'b0;
  end
endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb
  import gpio_arb_pkg::*;
#(
  parameter int NE = 8,
  parameter int NP = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NE-1:0]          m_vld_i,
  input  logic [NE-1:0]          m_tgt_i,
  input  logic [NE-1:0][NP-1:0]  m_mask_i,
  input  logic [NE-1:0][NP-1:0]  m_val_i,
  input  logic [NE-1:0]          s_vld_i,
  input  logic [NE-1:0]          s_tgt_i,
  input  logic [NE-1:0][NP-1:0]  s_mask_i,
  input  logic [NE-1:0][NP-1:0]  s_val_i,
  output logic [NP-1:0]          lvl_o,
  output logic [NP-1:0]          oe_o
);
  logic [NP-1:0] lvl_q, oe_q, lvl_d, oe_d, touch_l, touch_o;

  // ascending engine order, side after main: last writer wins
  always_comb begin
    lvl_d   = lvl_q;
    oe_d    = oe_q;
    touch_l = '0;
    touch_o = '0;
    for (int e = 0; e < NE; e++) begin
      if (m_vld_i[e]) begin
        if (m_tgt_i[e] == TGT_DIR) begin
          oe_d    = (oe_d & ~m_mask_i[e]) | (m_val_i[e] & m_mask_i[e]);
          touch_o = touch_o | m_mask_i[e];
        end else begin
          lvl_d   = (lvl_d & ~m_mask_i[e]) | (m_val_i[e] & m_mask_i[e]);
          touch_l = touch_l | m_mask_i[e];
        end
      end
      if (s_vld_i[e]) begin
        if (s_tgt_i[e] == TGT_DIR) begin
          oe_d    = (oe_d & ~s_mask_i[e]) | (s_val_i[e] & s_mask_i[e]);
          touch_o = touch_o | s_mask_i[e];
        end else begin
          lvl_d   = (lvl_d & ~s_mask_i[e]) | (s_val_i[e] & s_mask_i[e]);
          touch_l = touch_l | s_mask_i[e];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      oe_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      oe_q  <= oe_d;
    end
  end

  assign lvl_o = lvl_q;
  assign oe_o  = oe_q;

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (lvl_q == '0 && oe_q == '0));

  p_hold_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lvl_q ^ $past(lvl_q)) & ~$past(touch_l)) == '0);

  p_hold_dir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((oe_q ^ $past(oe_q)) & ~$past(touch_o)) == '0);

  p_top_side_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_vld_i[NE-1] && s_tgt_i[NE-1] == TGT_LEVEL)
    |=> (lvl_q & $past(s_mask_i[NE-1])) == $past(s_val_i[NE-1]));

  p_top_main_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_vld_i[NE-1] && m_tgt_i[NE-1] == TGT_DIR)
    |=> (oe_q & $past(m_mask_i[NE-1] & ~((s_vld_i[NE-1] && s_tgt_i[NE-1] == TGT_DIR)
           ? s_mask_i[NE-1] : '0)))
        == ($past(m_val_i[NE-1] & ~((s_vld_i[NE-1] && s_tgt_i[NE-1] == TGT_DIR)
           ? s_mask_i[NE-1] : '0))));
endmodule

// File: rtl/gpio_out_arbiter.sv
module gpio_out_arbiter #(
  parameter int NUM_ENG  = 8,
  parameter int NUM_PINS = 32,
  parameter int SET_BITS = 5,
  localparam int PW  = $clog2(NUM_PINS),
  localparam int CW  = $clog2(NUM_PINS + 1),
  localparam int SCW = $clog2(SET_BITS + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_ENG-1:0][PW-1:0]        out_base_i,
  input  logic [NUM_ENG-1:0][CW-1:0]        out_cnt_i,
  input  logic [NUM_ENG-1:0][PW-1:0]        set_base_i,
  input  logic [NUM_ENG-1:0][SCW-1:0]       set_cnt_i,
  input  logic [NUM_ENG-1:0][PW-1:0]        side_base_i,
  input  logic [NUM_ENG-1:0][SCW-1:0]       side_cnt_i,
  input  logic [NUM_ENG-1:0][PW-1:0]        in_base_i,
  input  logic [NUM_ENG-1:0][CW-1:0]        in_cnt_i,
  input  logic [NUM_ENG-1:0]                main_vld_i,
  input  logic [NUM_ENG-1:0]                main_src_i,
  input  logic [NUM_ENG-1:0]                main_tgt_i,
  input  logic [NUM_ENG-1:0][NUM_PINS-1:0]  main_data_i,
  input  logic [NUM_ENG-1:0]                side_vld_i,
  input  logic [NUM_ENG-1:0]                side_tgt_i,
  input  logic [NUM_ENG-1:0][SET_BITS-1:0]  side_data_i,
  input  logic [NUM_PINS-1:0]               gpio_i,
  output logic [NUM_PINS-1:0]               gpio_o,
  output logic [NUM_PINS-1:0]               gpio_oe_o,
  output logic [NUM_ENG-1:0][NUM_PINS-1:0]  in_data_o
);
  import gpio_arb_pkg::*;

  logic [NUM_ENG-1:0][NUM_PINS-1:0] out_mask, out_val, set_mask, set_val;
  logic [NUM_ENG-1:0][NUM_PINS-1:0] m_mask, m_val, s_mask, s_val;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    gpio_win_map #(.NP(NUM_PINS), .DW(NUM_PINS), .PW(PW), .CW(CW)) i_out_map (
      .base_i(out_base_i[e]), .cnt_i(out_cnt_i[e]), .data_i(main_data_i[e]),
      .mask_o(out_mask[e]), .val_o(out_val[e]));

    gpio_win_map #(.NP(NUM_PINS), .DW(SET_BITS), .PW(PW), .CW(SCW)) i_set_map (
      .base_i(set_base_i[e]), .cnt_i(set_cnt_i[e]),
      .data_i(main_data_i[e][SET_BITS-1:0]),
      .mask_o(set_mask[e]), .val_o(set_val[e]));

    gpio_win_map #(.NP(NUM_PINS), .DW(SET_BITS), .PW(PW), .CW(SCW)) i_side_map (
      .base_i(side_base_i[e]), .cnt_i(side_cnt_i[e]), .data_i(side_data_i[e]),
      .mask_o(s_mask[e]), .val_o(s_val[e]));

    gpio_in_gather #(.NP(NUM_PINS), .PW(PW), .CW(CW)) i_gather (
      .gpio_i(gpio_i), .base_i(in_base_i[e]), .cnt_i(in_cnt_i[e]),
      .data_o(in_data_o[e]));

    assign m_mask[e] = (main_src_i[e] == SRC_SET) ? set_mask[e] : out_mask[e];
    assign m_val[e]  = (main_src_i[e] == SRC_SET) ? set_val[e]  : out_val[e];
  end

  gpio_pin_arb #(.NE(NUM_ENG), .NP(NUM_PINS)) i_arb (
    .clk_i, .rst_ni,
    .m_vld_i(main_vld_i), .m_tgt_i(main_tgt_i), .m_mask_i(m_mask), .m_val_i(m_val),
    .s_vld_i(side_vld_i), .s_tgt_i(side_tgt_i), .s_mask_i(s_mask), .s_val_i(s_val),
    .lvl_o(gpio_o), .oe_o(gpio_oe_o));

  p_set_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_mask[0]) <= SET_BITS);
endmodule

// File: tb/test_gpio_out_arbiter.sv
`timescale 1ns/1ps
module test_gpio_out_arbiter;
  localparam int NE = 8, NP = 32, SB = 5, PW = 5, CW = 6, SCW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NE-1:0][PW-1:0]  out_base, set_base, side_base, in_base;
  logic [NE-1:0][CW-1:0]  out_cnt, in_cnt;
  logic [NE-1:0][SCW-1:0] set_cnt, side_cnt;
  logic [NE-1:0]          main_vld, main_src, main_tgt, side_vld, side_tgt;
  logic [NE-1:0][NP-1:0]  main_data, in_data;
  logic [NE-1:0][SB-1:0]  side_data;
  logic [NP-1:0]          gpio_in, gpio_out, gpio_oe;
  logic [NP-1:0]          exp_lvl, exp_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_out_arbiter i_gpio_out_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .out_base_i(out_base), .out_cnt_i(out_cnt),
    .set_base_i(set_base), .set_cnt_i(set_cnt),
    .side_base_i(side_base), .side_cnt_i(side_cnt),
    .in_base_i(in_base), .in_cnt_i(in_cnt),
    .main_vld_i(main_vld), .main_src_i(main_src), .main_tgt_i(main_tgt),
    .main_data_i(main_data),
    .side_vld_i(side_vld), .side_tgt_i(side_tgt), .side_data_i(side_data),
    .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe), .in_data_o(in_data));

  function automatic int lim(int c, int m);
    return (c < m) ? c : m;
  endfunction

  function automatic int offs(int p, int b);
    return (p - b + NP) % NP;
  endfunction

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference: per pin, engines ascending, main then side, last write wins
  task automatic model_step();
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < NE; e++) begin
        if (main_vld[e]) begin
          int b = main_src[e] ? int'(set_base[e]) : int'(out_base[e]);
          int c = main_src[e] ? lim(int'(set_cnt[e]), SB) : lim(int'(out_cnt[e]), NP);
          int o = offs(p, b);
          if (o < c) begin
            if (main_tgt[e]) exp_oe[p] = main_data[e][o];
            else             exp_lvl[p] = main_data[e][o];
          end
        end
        if (side_vld[e]) begin
          int o = offs(p, int'(side_base[e]));
          if (o < lim(int'(side_cnt[e]), SB)) begin
            if (side_tgt[e]) exp_oe[p] = side_data[e][o];
            else             exp_lvl[p] = side_data[e][o];
          end
        end
      end
    end
  endtask

  function automatic logic [NP-1:0] gather_ref(int e);
    logic [NP-1:0] r = '0;
    for (int i = 0; i < NP; i++)
      if (i < int'(in_cnt[e])) r[i] = gpio_in[(int'(in_base[e]) + i) % NP];
    return r;
  endfunction

  task automatic idle();
    main_vld = '0; side_vld = '0;
  endtask

  // call right after driving inputs at a falling edge
  task automatic run_cycle(string tag);
    #1;
    for (int e = 0; e < NE; e++) check("R10 input view", in_data[e], gather_ref(e));
    check("R9 level before edge", gpio_out, exp_lvl);
    check("R9 enable before edge", gpio_oe, exp_oe);
    model_step();
    @(posedge clk); #1;
    check({tag, " level"}, gpio_out, exp_lvl);
    check({tag, " enable"}, gpio_oe, exp_oe);
  endtask

  initial begin
    void'($urandom(1234));
    out_base = '0; set_base = '0; side_base = '0; in_base = '0;
    out_cnt = '0; set_cnt = '0; side_cnt = '0; in_cnt = '0;
    main_src = '0; main_tgt = '0; side_tgt = '0;
    main_data = '0; side_data = '0; gpio_in = '0;
    idle();
    exp_lvl = '0; exp_oe = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset level", gpio_out, '0);
    check("R1 reset enable", gpio_oe, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 wrap past top pin, data bits above count ignored
    @(negedge clk); idle();
    main_vld[2] = 1; main_src[2] = 0; main_tgt[2] = 0;
    out_base[2] = 5'd30; out_cnt[2] = 6'd4; main_data[2] = '1;
    run_cycle("R2 wrap");
    check("R2 wrap pins", gpio_out, 32'hC000_0003);

    // R3 set window capped at 5 pins, enable target (R5)
    @(negedge clk); idle();
    main_vld[1] = 1; main_src[1] = 1; main_tgt[1] = 1;
    set_base[1] = 5'd10; set_cnt[1] = 3'd7; main_data[1] = '1;
    run_cycle("R3 set cap");
    check("R5 enable only", gpio_oe, 32'h0000_7C00);
    check("R5 level kept", gpio_out, 32'hC000_0003);

    // R6 higher engine wins on overlap
    @(negedge clk); idle();
    main_vld[3] = 1; main_src[3] = 0; main_tgt[3] = 0; out_base[3] = 0; out_cnt[3] = 8;
    main_data[3] = 32'h0F;
    main_vld[5] = 1; main_src[5] = 0; main_tgt[5] = 0; out_base[5] = 0; out_cnt[5] = 8;
    main_data[5] = 32'hF0;
    run_cycle("R6 priority");
    check("R6 priority pins", gpio_out, 32'hC000_00F0);

    // R7 side beats main in one engine
    @(negedge clk); idle();
    main_vld[6] = 1; main_src[6] = 0; main_tgt[6] = 0; out_base[6] = 4; out_cnt[6] = 4;
    main_data[6] = '1;
    side_vld[6] = 1; side_tgt[6] = 0; side_base[6] = 4; side_cnt[6] = 4; side_data[6] = '0;
    run_cycle("R7 side wins");
    check("R7 side pins", gpio_out, 32'hC000_0000);

    // R8 nothing written: hold
    @(negedge clk); idle();
    run_cycle("R8 hold");
    check("R8 hold pins", gpio_oe, 32'h0000_7C00);

    // R4 side window wraps, capped to 5, enable target
    @(negedge clk); idle();
    side_vld[7] = 1; side_tgt[7] = 1; side_base[7] = 5'd29; side_cnt[7] = 3'd6;
    side_data[7] = 5'h1F;
    run_cycle("R4 side wrap");
    check("R4 side pins", gpio_oe, 32'hE000_7C03);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R10
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      for (int e = 0; e < NE; e++) begin
        out_base[e]  = PW'($urandom_range(NP-1, 0));
        set_base[e]  = PW'($urandom_range(NP-1, 0));
        side_base[e] = PW'($urandom_range(NP-1, 0));
        in_base[e]   = PW'($urandom_range(NP-1, 0));
        out_cnt[e]   = CW'($urandom_range(NP, 0));
        in_cnt[e]    = CW'($urandom_range(NP, 0));
        set_cnt[e]   = SCW'($urandom_range(7, 0));
        side_cnt[e]  = SCW'($urandom_range(7, 0));
        main_vld[e]  = ($urandom_range(3, 0) == 0);
        side_vld[e]  = ($urandom_range(3, 0) == 0);
        main_src[e]  = 1'($urandom);
        main_tgt[e]  = 1'($urandom);
        side_tgt[e]  = 1'($urandom);
        main_data[e] = $urandom;
        side_data[e] = SB'($urandom);
      end
      gpio_in = $urandom;
      run_cycle("R6 R7 R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule